// File: doc/BRIEF.md
# Dual-Clock Masked Word Memory

This block is a 4-Kbit synchronous memory that stores 256 words of 16 bits. It has two independent ports, each on its own clock. The write port stores a word at an 8-bit address. A 16-bit mask rides along with the data, so that chosen bits of the stored word stay unchanged while the others take the new value. The read port returns the word at its own 8-bit address through an output register.

Each port has a clock enable and an operation enable, and both must be high for that port to act on its clock edge. The read register has a synchronous active-low reset in the read domain. The write port has a synchronous active-low reset in the write domain, and it blocks stores while that reset is held. The stored words are never cleared by either reset.

The memory sits between two unrelated clock domains as a simple two-port buffer. The user must keep reads and writes of the same address apart in time.

Top module: `dcram_top`

## Requirements
- R1: The memory holds 256 independent 16-bit words, selected by an 8-bit address on each port. A store to one address leaves every other address unchanged.
- R2: A store happens only at a rising edge of wr_clk where wr_rst_n, wr_ce and wr_en are all 1. At any other edge the addressed word keeps its value.
- R3: During a store, each bit of the word where wr_mask is 1 keeps its previous value, and each bit where wr_mask is 0 takes the matching bit of wr_data.
- R4: When rd_ce and rd_en are both 1 at a rising edge of rd_clk, the word at rd_addr appears on rd_data after that edge. Reads issued on consecutive edges return one word per cycle.
- R5: At a rising edge of rd_clk where rd_ce or rd_en is 0, rd_data keeps its value.
- R6: When rd_rst_n is 0 at a rising edge of rd_clk, rd_data becomes zero, taking priority over a read. The stored words are kept through either reset.
- R7: The two ports run on unrelated clocks. A stream of stores and a stream of reads to disjoint addresses can run at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-port clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain; blocks stores |
| wr_ce | input | 1 | Write-port clock enable |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 8 | Write word address |
| wr_data | input | 16 | Data to store |
| wr_mask | input | 16 | Per-bit protect: 1 keeps the stored bit, 0 writes it |
| rd_clk | input | 1 | Read-port clock |
| rd_rst_n | input | 1 | Synchronous active-low reset of the read register |
| rd_ce | input | 1 | Read-port clock enable |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 8 | Read word address |
| rd_data | output | 16 | Registered read word |

## Verification
The bench builds the block with its default sizes of 8 address bits and 16 data bits. At that size every one of the 256 words can be filled, masked, rewritten and read back with a pipelined sweep in a few thousand cycles. Each address gets its own arithmetic data and mask pattern, including the all-protect and all-write masks. The write clock and the read clock run at different periods so that concurrent traffic on disjoint address halves exercises the two-domain operation.

// File: rtl/dcram_pkg.sv
`timescale 1ns/1ps
// dcram_pkg: shared sizing constants for the dual-clock masked memory.
// Assumes: consumers take these as defaults and may override them per instance.
package dcram_pkg;
    localparam int unsigned DEF_ADDR_W = 8;
    localparam int unsigned DEF_DATA_W = 16;
endpackage

// File: rtl/dcram_wr_gate.sv
`timescale 1ns/1ps
// dcram_wr_gate: turns the write-port controls into per-bit write enables.
// A bit is enabled only when reset is released, both enables are high and
// its protect bit is 0.
// Assumes: purely combinational; the array samples the result on wr_clk.
module dcram_wr_gate #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              rst_n,
    input  logic              ce,
    input  logic              en,
    input  logic [DATA_W-1:0] mask,
    output logic              go,
    output logic [DATA_W-1:0] bit_we
);
    // Qualify the store and expand the mask into per-bit enables.
    always_comb begin
        go     = rst_n & ce & en;
        bit_we = go ? ~mask : '0;
    end
endmodule

// File: rtl/dcram_array.sv
`timescale 1ns/1ps
// dcram_array: storage of DEPTH words, written bit by bit on wr_clk and
// read combinationally at the read address.
// Assumes: bit_we is already qualified by reset and enables; contents have
// no reset; same-address collisions across domains are left to the user.
module dcram_array #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] wr_mask,
    input  logic [DATA_W-1:0] bit_we,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] wr_old;

    // Store each enabled bit of the write data at the write address.
    always_ff @(posedge wr_clk) begin
        for (int b = 0; b < DATA_W; b++) begin
            if (bit_we[b]) begin
                mem_q[wr_addr][b] <= wr_data[b];
            end
        end
    end

    // Present the addressed words to the read register and the checks.
    always_comb begin
        rd_word = mem_q[rd_addr];
        wr_old  = mem_q[wr_addr];
    end

    // R3
    property protect_bits_chk_p;
        @(posedge wr_clk) disable iff (!wr_rst_n)
        wr_go |=> ((mem_q[$past(wr_addr)] & $past(wr_mask)) ===
                   ($past(wr_old) & $past(wr_mask)));
    endproperty
    protect_bits_chk: assert property (protect_bits_chk_p);

    // R3
    property open_bits_chk_p;
        @(posedge wr_clk) disable iff (!wr_rst_n)
        wr_go |=> ((mem_q[$past(wr_addr)] & ~$past(wr_mask)) ===
                   ($past(wr_data) & ~$past(wr_mask)));
    endproperty
    open_bits_chk: assert property (open_bits_chk_p);

    // R2
    property idle_write_chk_p;
        @(posedge wr_clk) disable iff (!wr_rst_n)
        !wr_go |=> (mem_q[$past(wr_addr)] === $past(wr_old));
    endproperty
    idle_write_chk: assert property (idle_write_chk_p);
endmodule

// File: rtl/dcram_rd_reg.sv
`timescale 1ns/1ps
// dcram_rd_reg: output register of the read port, loaded on rd_clk when
// both read enables are high and cleared by a synchronous active-low reset.
// Assumes: word_in is the array word at the current read address.
module dcram_rd_reg #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              en,
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] data_q
);
    // Capture the addressed word on an enabled read, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (ce && en) begin
            data_q <= word_in;
        end
    end

    // R5
    property hold_when_idle_chk_p;
        @(posedge clk) disable iff (!rst_n)
        !(ce && en) |=> $stable(data_q);
    endproperty
    hold_when_idle_chk: assert property (hold_when_idle_chk_p);

    // R6
    property reset_clears_chk_p;
        @(posedge clk) !rst_n |=> (data_q == '0);
    endproperty
    reset_clears_chk: assert property (reset_clears_chk_p);
endmodule

// File: rtl/dcram_top.sv
`timescale 1ns/1ps
// dcram_top: dual-clock memory with a masked write port and a registered
// read port. Write and read logic live in separate clock domains.
// Assumes: the user keeps same-address read and write apart in time;
// neither reset clears the stored words.
module dcram_top
    import dcram_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_ce,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] wr_mask,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_ce,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic              wr_go;
    logic [DATA_W-1:0] bit_we;
    logic [DATA_W-1:0] rd_word;

    dcram_wr_gate #(.DATA_W(DATA_W)) wr_gate_i (
        .rst_n  (wr_rst_n),
        .ce     (wr_ce),
        .en     (wr_en),
        .mask   (wr_mask),
        .go     (wr_go),
        .bit_we (bit_we)
    );

    dcram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_go    (wr_go),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_mask  (wr_mask),
        .bit_we   (bit_we),
        .rd_addr  (rd_addr),
        .rd_word  (rd_word)
    );

    dcram_rd_reg #(.DATA_W(DATA_W)) rd_reg_i (
        .clk     (rd_clk),
        .rst_n   (rd_rst_n),
        .ce      (rd_ce),
        .en      (rd_en),
        .word_in (rd_word),
        .data_q  (rd_data)
    );
endmodule

// File: tb/dcram_top_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps all addresses with arithmetic patterns against a bench model.
module dcram_top_tb_top;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic          wr_clk = 0, rd_clk = 0;
    logic          wr_rst_n = 0, rd_rst_n = 0;
    logic          wr_ce = 0, wr_en = 0, rd_ce = 0, rd_en = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0, wr_mask = '0;
    logic [DW-1:0] rd_data;

    logic [DW-1:0] model [DEPTH];
    int n_run = 0, n_fail = 0;

    always #5 wr_clk = ~wr_clk;   // 100 MHz write clock
    always #7 rd_clk = ~rd_clk;   // unrelated read clock

    dcram_top #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_ce(wr_ce), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_ce(rd_ce), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [DW-1:0] pat(int a, int salt);
        return 16'((a * 40503 + salt * 7919) ^ 16'h5A5A);
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One store; model follows when the store is qualified.
    task automatic wr_word(int a, logic [DW-1:0] d, logic [DW-1:0] m,
                           logic ce, logic en);
        @(negedge wr_clk);
        wr_addr = AW'(a); wr_data = d; wr_mask = m; wr_ce = ce; wr_en = en;
        @(negedge wr_clk);
        if (wr_rst_n && ce && en) model[a] = (model[a] & m) | (d & ~m);
        wr_ce = 0; wr_en = 0;
    endtask

    // Pipelined read sweep: one address per read-clock cycle.
    task automatic rd_sweep(int lo, int hi, string req);
        @(negedge rd_clk);
        rd_addr = AW'(lo); rd_ce = 1; rd_en = 1;
        for (int a = lo; a <= hi; a++) begin
            @(negedge rd_clk);
            check(req, rd_data, model[a]);
            if (a < hi) rd_addr = AW'(a + 1);
        end
        rd_ce = 0; rd_en = 0;
    endtask

    initial begin : watchdog
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] held;
        repeat (4) @(negedge rd_clk);
        check("R6 reset value", rd_data, '0);
        wr_rst_n = 1; rd_rst_n = 1;

        // R1: fill every word, unmasked, then read all back in a stream (R4).
        for (int a = 0; a < DEPTH; a++) wr_word(a, pat(a, 1), '0, 1, 1);
        rd_sweep(0, DEPTH - 1, "R1/R4 fill readback");

        // R3: masked rewrite; address 0 protects all, address 1 protects none.
        for (int a = 0; a < DEPTH; a++) begin
            logic [DW-1:0] m;
            m = (a == 0) ? '1 : (a == 1) ? '0 : 16'((a * 257) ^ 16'hF0F0);
            wr_word(a, ~model[a], m, 1, 1);
        end
        rd_sweep(0, DEPTH - 1, "R3 masked write");

        // R2: stores lacking an enable or during reset are ignored.
        for (int a = 0; a < 64; a++) wr_word(a, pat(a, 2), '0, 0, 1);
        for (int a = 64; a < 128; a++) wr_word(a, pat(a, 3), '0, 1, 0);
        wr_rst_n = 0;
        for (int a = 128; a < 144; a++) wr_word(a, pat(a, 4), '0, 1, 1);
        wr_rst_n = 1;
        rd_sweep(0, 143, "R2 gated write");

        // R5: output holds while either read enable is low.
        rd_sweep(5, 5, "R4 single read");
        held = rd_data;
        @(negedge rd_clk); rd_addr = 8'd6; rd_ce = 0; rd_en = 1;
        repeat (3) begin @(negedge rd_clk); check("R5 ce low hold", rd_data, held); end
        rd_ce = 1; rd_en = 0;
        repeat (3) begin @(negedge rd_clk); check("R5 en low hold", rd_data, held); end
        rd_ce = 0;

        // R7: concurrent stores (low half) and reads (high half).
        fork
            for (int a = 0; a < DEPTH / 2; a++) wr_word(a, pat(a, 5), '0, 1, 1);
            rd_sweep(DEPTH / 2, DEPTH - 1, "R7 concurrent read");
        join
        rd_sweep(0, DEPTH / 2 - 1, "R7 concurrent write");

        // R6: read reset clears output even with a read requested; words kept.
        @(negedge rd_clk); rd_rst_n = 0; rd_ce = 1; rd_en = 1; rd_addr = 8'd9;
        @(negedge rd_clk); check("R6 reset over read", rd_data, '0);
        rd_rst_n = 1; rd_ce = 0; rd_en = 0;
        @(negedge rd_clk); check("R6 cleared hold", rd_data, '0);
        rd_sweep(0, DEPTH - 1, "R6 contents kept");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule